// File: doc/BRIEF.md
# Simultaneous-Access Interleaved Line Fetcher

This block holds a low-order interleaved word memory split across a parameterised number of banks, and serves whole cache lines from it. The low address bits pick the bank and the high bits pick the row inside the bank. A line is one row across every bank, so the line length equals the bank count.

When a fill request is taken, one shared row register is loaded. All banks then start the same access together and finish together after a fixed access time. After that, the words leave through one output port at one word per cycle. They always come out in bank order starting at bank 0, whatever word the requester needs. The low address bits of the request do not change which line is read. They only mark which streamed word is the critical one.

A simple word write port loads the banks. The requester uses the critical flag to pick out the word it was waiting for, and it takes the rest of the stream to fill the line.

Top module: `lf_line_fetcher`

## Requirements
- R1: Word k of a streamed line carries the data stored at word address row*NUM_BANKS + k, where the row is the request address shifted right by log2(NUM_BANKS).
- R2: The request is taken on the clock edge where req_valid and req_ready are both high. Word k is presented in the cycle that follows edge ACCESS_LAT+1+k after that edge. With the defaults this is edge 9+k.
- R3: req_ready is high after reset and while the block is idle. It goes low from the edge that takes a request until the edge that presents the last word, and it is high again from that edge on.
- R4: out_valid stays high for exactly NUM_BANKS consecutive cycles per line. out_word counts 0, 1, ..., NUM_BANKS-1 in those cycles and names the bank of the word shown.
- R5: out_critical is high on exactly one word of each line: the word whose index equals the low log2(NUM_BANKS) bits of the request address. The stream still begins at word 0.
- R6: The low log2(NUM_BANKS) bits of the request address do not change the data returned. Two requests that differ only in those bits stream identical words.
- R7: A write with wr_en high stores wr_data at bank wr_addr[log2(NUM_BANKS)-1:0], row wr_addr[ADDR_W-1:log2(NUM_BANKS)], on that clock edge. A later fill of that line returns the new word.
- R8: req_valid seen while req_ready is low is ignored. It starts no stream and does not change the line in flight.
- R9: While rst is high and after it is released, out_valid is low until a request has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fill request strobe |
| req_addr | input | ADDR_W | Word address; high bits pick the line, low bits the critical word |
| req_ready | output | 1 | Block can take a request |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | ADDR_W | Word address for the write |
| wr_data | input | DATA_W | Data for the write |
| out_valid | output | 1 | A line word is presented |
| out_data | output | DATA_W | The word presented |
| out_word | output | log2(NUM_BANKS) | Bank index of the word presented |
| out_critical | output | 1 | The presented word is the requested one |

## Verification
Fills are requested with critical offsets 0, a middle value and the last value. A critical word of 0 cannot be told apart from plain in-order streaming, but the middle and last offsets show that the order is fixed while the flag moves. Requests to the first and last rows, and pairs of requests that differ only in the offset bits, separate row decoding from offset handling. Back-to-back requests taken on the first ready cycle check the exact latency and the ready window. A request held during a busy stream, and a refetch after overwriting one word, show that busy requests are dropped and that the bank data is read at the access.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [1:0] {
        LF_IDLE   = 2'd0,
        LF_ACCESS = 2'd1,
        LF_STREAM = 2'd2
    } lf_state_e;

    // Width of an index that can name n distinct items (minimum one bit).
    function automatic int unsigned lf_idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lf_bank.sv
module lf_bank #(
    parameter int unsigned ROW_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cap_en,
    input  logic [ROW_W-1:0]  cap_row,
    output logic [DATA_W-1:0] word_q
);
    localparam int unsigned DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_hit) begin
            cells[wr_row] <= wr_data;
        end
    end

    // Data register of this bank: loaded when the shared access completes.
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (cap_en) begin
            word_q <= cells[cap_row];
        end
    end

endmodule

// File: rtl/lf_fetch_ctrl.sv
module lf_fetch_ctrl
    import lf_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 8,
    parameter int unsigned ACCESS_LAT = 8,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     req_ready,
    output logic                     cap_en,
    output logic [ADDR_W-lf_idx_w(NUM_BANKS)-1:0] cap_row,
    output logic [lf_idx_w(NUM_BANKS)-1:0]        crit_off,
    output logic                     beat_valid,
    output logic [lf_idx_w(NUM_BANKS)-1:0]        beat_idx
);
    localparam int unsigned IDX_W = lf_idx_w(NUM_BANKS);
    localparam int unsigned ROW_W = ADDR_W - IDX_W;
    localparam int unsigned CNT_W = lf_idx_w(ACCESS_LAT);
    localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(ACCESS_LAT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BANKS - 1);

    lf_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ROW_W-1:0]  row_q;
    logic [IDX_W-1:0]  off_q;
    logic              access_done;

    assign access_done = (state_q == LF_ACCESS) && (cnt_q == LAT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LF_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            row_q   <= '0;
            off_q   <= '0;
        end else begin
            unique case (state_q)
                LF_IDLE: begin
                    if (req_valid) begin
                        row_q   <= req_addr[ADDR_W-1:IDX_W];
                        off_q   <= req_addr[IDX_W-1:0];
                        cnt_q   <= '0;
                        state_q <= LF_ACCESS;
                    end
                end
                LF_ACCESS: begin
                    if (access_done) begin
                        idx_q   <= '0;
                        state_q <= LF_STREAM;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                LF_STREAM: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_LAST) begin
                        state_q <= LF_IDLE;
                    end
                end
                default: state_q <= LF_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == LF_IDLE);
    assign cap_en     = access_done;
    assign cap_row    = row_q;
    assign crit_off   = off_q;
    assign beat_valid = (state_q == LF_STREAM);
    assign beat_idx   = idx_q;

endmodule

// File: rtl/lf_stream_out.sv
module lf_stream_out
    import lf_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   beat_valid,
    input  logic [lf_idx_w(NUM_BANKS)-1:0]         beat_idx,
    input  logic [lf_idx_w(NUM_BANKS)-1:0]         crit_off,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]       bank_words,
    output logic                                   out_valid,
    output logic [DATA_W-1:0]                      out_data,
    output logic [lf_idx_w(NUM_BANKS)-1:0]         out_word,
    output logic                                   out_critical
);
    localparam int unsigned IDX_W = lf_idx_w(NUM_BANKS);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  word;
        logic              crit;
    } beat_t;

    beat_t beat_d, beat_q;

    always_comb begin
        beat_d       = '0;
        beat_d.valid = beat_valid;
        if (beat_valid) begin
            beat_d.data = bank_words[beat_idx];
            beat_d.word = beat_idx;
            beat_d.crit = (beat_idx == crit_off);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign out_valid    = beat_q.valid;
    assign out_data     = beat_q.data;
    assign out_word     = beat_q.word;
    assign out_critical = beat_q.crit;

endmodule

// File: rtl/lf_line_fetcher.sv
module lf_line_fetcher
    import lf_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 8,
    parameter int unsigned ACCESS_LAT = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             req_valid,
    input  logic [ADDR_W-1:0]                req_addr,
    output logic                             req_ready,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic                             out_valid,
    output logic [DATA_W-1:0]                out_data,
    output logic [lf_idx_w(NUM_BANKS)-1:0]   out_word,
    output logic                             out_critical
);
    localparam int unsigned IDX_W = lf_idx_w(NUM_BANKS);
    localparam int unsigned ROW_W = ADDR_W - IDX_W;

    logic                               cap_en;
    logic [ROW_W-1:0]                   cap_row;
    logic [IDX_W-1:0]                   crit_off;
    logic                               beat_valid;
    logic [IDX_W-1:0]                   beat_idx;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_words;

    lf_fetch_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .ACCESS_LAT(ACCESS_LAT),
        .ADDR_W    (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .cap_en    (cap_en),
        .cap_row   (cap_row),
        .crit_off  (crit_off),
        .beat_valid(beat_valid),
        .beat_idx  (beat_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_hit;
        assign wr_hit = wr_en && (wr_addr[IDX_W-1:0] == IDX_W'(b));

        lf_bank #(
            .ROW_W (ROW_W),
            .DATA_W(DATA_W)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (wr_hit),
            .wr_row (wr_addr[ADDR_W-1:IDX_W]),
            .wr_data(wr_data),
            .cap_en (cap_en),
            .cap_row(cap_row),
            .word_q (bank_words[b])
        );
    end

    lf_stream_out #(
        .NUM_BANKS(NUM_BANKS),
        .DATA_W   (DATA_W)
    ) u_out (
        .clk         (clk),
        .rst         (rst),
        .beat_valid  (beat_valid),
        .beat_idx    (beat_idx),
        .crit_off    (crit_off),
        .bank_words  (bank_words),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_word    (out_word),
        .out_critical(out_critical)
    );

endmodule

// File: rtl/lf_line_fetcher_chk.sv
module lf_line_fetcher_chk
    import lf_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 8,
    parameter int unsigned ACCESS_LAT = 8,
    parameter int unsigned ADDR_W     = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           req_valid,
    input logic                           req_ready,
    input logic                           out_valid,
    input logic [lf_idx_w(NUM_BANKS)-1:0] out_word,
    input logic                           out_critical
);
    localparam int unsigned IDX_W = lf_idx_w(NUM_BANKS);
    localparam int unsigned SW    = $clog2(ACCESS_LAT + NUM_BANKS + 4) + 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BANKS - 1);

    logic [SW-1:0] since_acc;
    logic          run;

    // Cycles elapsed since the last accepted request.
    always_ff @(posedge clk) begin
        if (rst) begin
            since_acc <= '0;
            run       <= 1'b0;
        end else if (req_valid && req_ready) begin
            since_acc <= '0;
            run       <= 1'b1;
        end else if (run && since_acc != '1) begin
            since_acc <= since_acc + 1'b1;
        end
    end

    a_r2_first_word_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (run && since_acc == SW'(ACCESS_LAT + 1)));

    a_r3_ready_drops_on_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_busy_while_streaming: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word != IDX_LAST) |-> !req_ready);

    a_r4_word_order: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word != IDX_LAST) |=>
            (out_valid && out_word == $past(out_word) + IDX_W'(1)));

    a_r4_stream_starts_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_word == '0));

    a_r5_flag_only_on_valid: assert property (@(posedge clk) disable iff (rst)
        out_critical |-> out_valid);

endmodule

bind lf_line_fetcher lf_line_fetcher_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ACCESS_LAT(ACCESS_LAT),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .out_valid   (out_valid),
    .out_word    (out_word),
    .out_critical(out_critical)
);

// File: tb/lf_line_fetcher_bench.sv
`timescale 1ns/1ps
module lf_line_fetcher_bench;
    localparam int NB   = 8;
    localparam int LAT  = 8;
    localparam int AW   = 8;
    localparam int DW   = 32;
    localparam int IW   = 3;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [IW-1:0] out_word;
    logic          out_critical;

    always #10 clk = ~clk;

    lf_line_fetcher #(
        .NUM_BANKS(NB), .ACCESS_LAT(LAT), .ADDR_W(AW), .DATA_W(DW)
    ) u_lf_line_fetcher (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_data(out_data),
        .out_word(out_word), .out_critical(out_critical)
    );

    int total = 0;
    int bad   = 0;
    int ecount = 0;
    int busy_from = -1;
    int busy_to   = -1;
    logic [DW-1:0] ref_mem [WORDS];
    logic [DW-1:0] exp_data [int];
    int            exp_word [int];
    bit            exp_crit [int];
    bit            finished = 1'b0;

    always @(posedge clk) ecount <= ecount + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h",
                     req, what, ecount, act, exp);
        end
    endtask

    // Reference model comparison on every cycle.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit exp_rdy;
            exp_rdy = !(ecount >= busy_from && ecount <= busy_to);
            check(req_ready == exp_rdy, "R3", "req_ready", req_ready, exp_rdy);
            if (exp_word.exists(ecount)) begin
                check(out_valid == 1'b1, "R2", "out_valid", out_valid, 1);
                check(out_data == exp_data[ecount], "R1 R6 R7", "out_data",
                      out_data, exp_data[ecount]);
                check(out_word == IW'(exp_word[ecount]), "R4", "out_word",
                      out_word, exp_word[ecount]);
                check(out_critical == exp_crit[ecount], "R5", "out_critical",
                      out_critical, exp_crit[ecount]);
            end else if (out_valid) begin
                check(1'b0, "R8", "unexpected out_valid", out_valid, 0);
            end
        end
    end

    task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        ref_mem[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic issue(input logic [AW-1:0] a);
        int nacc;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        nacc = ecount + 1;
        busy_from = nacc;
        busy_to   = nacc + LAT + NB - 1;
        for (int k = 0; k < NB; k++) begin
            int slot;
            slot = nacc + LAT + 1 + k;
            exp_data[slot] = ref_mem[{a[AW-1:IW], IW'(k)}];
            exp_word[slot] = k;
            exp_crit[slot] = (k == int'(a[IW-1:0]));
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(req_ready && ecount > busy_to + 2)) @(negedge clk);
    endtask

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: idle state after reset
        check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        check(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);

        // R7: load every word through the write port
        for (int i = 0; i < WORDS; i++) begin
            write_word(AW'(i), 32'hC0DE_0000 ^ (32'(i) * 32'h0001_0203) ^ 32'(i << 24));
        end

        issue(8'h00);          // R5: critical word 0, first row
        wait_idle();
        issue(8'h2D);          // R5: critical word in the middle
        wait_idle();
        issue(8'hFF);          // R1: last row, last word critical
        issue(8'hF8);          // R6: same row, offset 0, taken back to back (R2 R3)
        wait_idle();

        // R8: request held while busy is dropped
        issue(8'h41);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_addr = 8'h93;
        repeat (8) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();

        // R7: overwrite one word, refetch the line with a different offset (R6)
        write_word(8'h2B, 32'h1234_5678);
        issue(8'h2E);
        wait_idle();
        issue(8'h5A);
        issue(8'h5C);
        wait_idle();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired: actual=%0d expected=%0d", 20000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule